// File: doc/BRIEF.md
# Region Descriptor List Sequencer

This block is the control engine of a memory integrity monitor. When started, it walks a list of region descriptors kept in system memory. It reads each four-word descriptor through a simple request/response read port and latches the words into context registers. It then hands the external hash engine a run of 64-byte block-read transfers that cover the region's data. A region can also chain into a secondary list of further data areas. Those areas are gathered into the same digest under the region's unchanged configuration. When a region's last block has been accepted, the sequencer raises a one-cycle digest-done event that carries the region index and the hash algorithm. It then moves to the next descriptor, returns to the head of the list, or stops, as the end-of-list flags direct.

Descriptor layout, at offsets +0, +4, +8 and +12 from the descriptor base:
- +0: data start address.
- +4: configuration. Bit 0 is the return-to-head flag, bit 1 is the stop flag, and bits 13:12 select the algorithm (0 = SHA1, 1 = SHA224, 2 = SHA256).
- +8: control. Bits 15:0 hold the block count minus one.
- +12: secondary-list pointer, where 0 means there is no secondary list.

A secondary descriptor is three words: data address, control in the same format, and next pointer, where 0 ends the list. The `bw_sel` input B throttles memory load by placing 2^B idle cycles between consecutive block reads of one data area. B=0 means no gaps.

FSM states: IDLE (waiting for `start`), DREQ/DWAIT (request and receive one main-descriptor word), STREAM (offer a block to the hash engine), THROT (bandwidth gap), SREQ/SWAIT (request and receive one secondary-descriptor word), DONE (digest-done event and list-advance decision). The transitions are:
- IDLE→DREQ on start.
- DREQ→DWAIT always.
- DWAIT→DREQ when a word arrives and the word is not the fourth.
- DWAIT→STREAM when the fourth word arrives.
- STREAM→THROT or STREAM→STREAM when a block is accepted and more blocks remain in the area.
- STREAM→SREQ at the end of an area when the secondary pointer is nonzero.
- STREAM→DONE at the end of an area when the secondary pointer is zero.
- THROT→STREAM when the gap expires.
- SREQ→SWAIT always.
- SWAIT→SREQ or SWAIT→STREAM as words arrive.
- DONE→IDLE when the stop flag is set.
- DONE→DREQ otherwise.

Top module: `rdl_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_req`, `blk_valid` and `dig_done` are all low.
- R2: A pulse on `start` in IDLE causes four single-cycle reads at `list_base`, +4, +8 and +12. There is at most one outstanding read at a time, and no block is offered before the fourth word has returned.
- R3: A region streams (control bits 15:0)+1 blocks from its start address. Block addresses rise by 64 per block, and every block carries the algorithm from configuration bits 13:12.
- R4: `blk_first` is high only on the first block of a region, and `blk_last` is high only on the final block of its final area.
- R5: A nonzero pointer at +12 makes the sequencer read a three-word secondary descriptor there (address, control, next pointer) after the main area. It streams that area with the region's algorithm and continues until a next pointer of 0 is reached.
- R6: One cycle after the final block of a region is accepted, `dig_done` pulses for exactly one cycle, with `dig_region` and `dig_alg` set to the region's index and algorithm.
- R7: A region whose configuration has bit 1 set ends the walk: `busy` falls and no further reads occur. This holds even when bit 0 is also set.
- R8: A region with bit 0 set and bit 1 clear is followed by a re-read of the descriptor at `list_base`, reported as region 0.
- R9: A region with neither flag set is followed by the descriptor 16 bytes further on, with the region index one higher. After region 3 the walk returns to `list_base` and region 0.
- R10: With B>0, consecutive blocks of one data area are accepted 2^B+1 cycles apart when `blk_ready` is held high. With B=0 they are accepted in back-to-back cycles.
- R11: While `blk_valid` is high and `blk_ready` is low, `blk_valid`, `blk_addr` and `blk_alg` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (used in IDLE only) |
| list_base | input | 32 | Address of the first main descriptor |
| bw_sel | input | 3 | Bandwidth throttle exponent B |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| blk_valid | output | 1 | Block transfer offered to hash engine |
| blk_ready | input | 1 | Hash engine accepts block |
| blk_addr | output | 32 | Block start address |
| blk_alg | output | 2 | Algorithm select for the block |
| blk_first | output | 1 | First block of the region |
| blk_last | output | 1 | Final block of the region |
| dig_done | output | 1 | Region digest-done event |
| dig_region | output | 2 | Region index of the event |
| dig_alg | output | 2 | Algorithm of the event |
| busy | output | 1 | Walk in progress |

## Verification
The bench aims at the area boundary where a secondary pointer must be followed. A sequencer that dropped that pointer would report the digest after the main area, so the scoreboard would be left holding unconsumed gather blocks. A descriptor with both end flags set catches a priority inversion, because such a design would start a fresh walk instead of going idle. A list of four flagless regions catches a missing index wrap, since the next read would go to the fifth slot. The throttle gap is measured cycle by cycle between blocks of one area, and a stalled hash engine checks that the offered block is not lost or advanced.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DREQ,
        S_DWAIT,
        S_STREAM,
        S_THROT,
        S_SREQ,
        S_SWAIT,
        S_DONE
    } rdl_state_e;

    localparam int CFG_WRAP_BIT = 0;
    localparam int CFG_STOP_BIT = 1;
    localparam int CFG_ALG_LSB  = 12;
    localparam int BLK_BYTES    = 64;
    localparam int DESC_BYTES   = 16;
    localparam int WORD_BYTES   = 4;

    // context field slots (main-descriptor order)
    localparam logic [1:0] FLD_ADDR = 2'd0;
    localparam logic [1:0] FLD_CFG  = 2'd1;
    localparam logic [1:0] FLD_CTRL = 2'd2;
    localparam logic [1:0] FLD_NEXT = 2'd3;
endpackage

// File: rtl/rdl_throttle.sv
module rdl_throttle #(
    parameter int BW_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BW_W-1:0] bw_sel,
    input  logic            arm,
    output logic            expired
);
    localparam int CNT_W = (1 << BW_W);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= (CNT_W'(1) << bw_sel) - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rdl_ctx.sv
module rdl_ctx
    import rdl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [1:0]        ld_field,
    input  logic [DATA_W-1:0] ld_word,
    input  logic              adv,
    output logic [ADDR_W-1:0] area_addr,
    output logic [SIZE_W-1:0] area_rem,
    output logic              cfg_wrap,
    output logic              cfg_stop,
    output logic [1:0]        cfg_alg,
    output logic [ADDR_W-1:0] sec_ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            area_addr <= '0;
            area_rem  <= '0;
            cfg_wrap  <= 1'b0;
            cfg_stop  <= 1'b0;
            cfg_alg   <= '0;
            sec_ptr   <= '0;
        end else if (ld_en) begin
            unique case (ld_field)
                FLD_ADDR: area_addr <= ld_word[ADDR_W-1:0];
                FLD_CFG: begin
                    cfg_wrap <= ld_word[CFG_WRAP_BIT];
                    cfg_stop <= ld_word[CFG_STOP_BIT];
                    cfg_alg  <= ld_word[CFG_ALG_LSB +: 2];
                end
                FLD_CTRL: area_rem <= ld_word[SIZE_W-1:0];
                FLD_NEXT: sec_ptr  <= ld_word[ADDR_W-1:0];
            endcase
        end else if (adv) begin
            area_addr <= area_addr + ADDR_W'(BLK_BYTES);
            if (area_rem != '0) area_rem <= area_rem - SIZE_W'(1);
        end
    end
endmodule

// File: rtl/rdl_seq.sv
module rdl_seq
    import rdl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int SIZE_W      = 16,
    parameter int BW_W        = 3,
    parameter int NUM_REGIONS = 4,
    localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [BW_W-1:0]   bw_sel,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              blk_valid,
    input  logic              blk_ready,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [1:0]        blk_alg,
    output logic              blk_first,
    output logic              blk_last,
    output logic              dig_done,
    output logic [REG_W-1:0]  dig_region,
    output logic [1:0]        dig_alg,
    output logic              busy
);
    rdl_state_e state, state_nx;

    logic [ADDR_W-1:0] desc_ptr, fetch_ptr;
    logic [1:0]        widx;
    logic [REG_W-1:0]  region;
    logic              first_pend;

    logic [ADDR_W-1:0] area_addr, sec_ptr;
    logic [SIZE_W-1:0] area_rem;
    logic              cfg_wrap, cfg_stop;
    logic [1:0]        cfg_alg;
    logic              thr_expired;

    logic       ld_en, adv, thr_arm, area_end, wrap_now;
    logic [1:0] ld_field;

    assign ld_en    = ((state == S_DWAIT) || (state == S_SWAIT)) && mem_rvalid;
    assign ld_field = (state == S_DWAIT) ? widx :
                      (widx == 2'd0) ? FLD_ADDR :
                      (widx == 2'd1) ? FLD_CTRL : FLD_NEXT;
    assign adv      = (state == S_STREAM) && blk_ready;
    assign area_end = (area_rem == '0);
    assign thr_arm  = adv && !area_end;
    assign wrap_now = cfg_wrap || (region == REG_W'(NUM_REGIONS - 1));

    rdl_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_field (ld_field),
        .ld_word  (mem_rdata),
        .adv      (adv),
        .area_addr(area_addr),
        .area_rem (area_rem),
        .cfg_wrap (cfg_wrap),
        .cfg_stop (cfg_stop),
        .cfg_alg  (cfg_alg),
        .sec_ptr  (sec_ptr)
    );

    rdl_throttle #(.BW_W(BW_W)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .bw_sel (bw_sel),
        .arm    (thr_arm),
        .expired(thr_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_DREQ;
            S_DREQ:  state_nx = S_DWAIT;
            S_DWAIT: if (mem_rvalid) state_nx = (widx == 2'd3) ? S_STREAM : S_DREQ;
            S_STREAM: if (blk_ready) begin
                if (!area_end)             state_nx = (bw_sel != '0) ? S_THROT : S_STREAM;
                else if (sec_ptr != '0)    state_nx = S_SREQ;
                else                       state_nx = S_DONE;
            end
            S_THROT: if (thr_expired) state_nx = S_STREAM;
            S_SREQ:  state_nx = S_SWAIT;
            S_SWAIT: if (mem_rvalid) state_nx = (widx == 2'd2) ? S_STREAM : S_SREQ;
            S_DONE:  state_nx = cfg_stop ? S_IDLE : S_DREQ;
        endcase
    end

    // walk pointers and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr   <= '0;
            fetch_ptr  <= '0;
            widx       <= '0;
            region     <= '0;
            first_pend <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    desc_ptr  <= list_base;
                    fetch_ptr <= list_base;
                    widx      <= '0;
                    region    <= '0;
                end
                S_DWAIT: if (mem_rvalid) begin
                    fetch_ptr <= fetch_ptr + ADDR_W'(WORD_BYTES);
                    widx      <= widx + 2'd1;
                    if (widx == 2'd3) first_pend <= 1'b1;
                end
                S_STREAM: if (blk_ready) begin
                    first_pend <= 1'b0;
                    if (area_end && sec_ptr != '0) begin
                        fetch_ptr <= sec_ptr;
                        widx      <= '0;
                    end
                end
                S_SWAIT: if (mem_rvalid) begin
                    fetch_ptr <= fetch_ptr + ADDR_W'(WORD_BYTES);
                    widx      <= (widx == 2'd2) ? 2'd0 : widx + 2'd1;
                end
                S_DONE: begin
                    widx <= '0;
                    if (wrap_now) begin
                        desc_ptr  <= list_base;
                        fetch_ptr <= list_base;
                        region    <= '0;
                    end else begin
                        desc_ptr  <= desc_ptr + ADDR_W'(DESC_BYTES);
                        fetch_ptr <= desc_ptr + ADDR_W'(DESC_BYTES);
                        region    <= region + REG_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state == S_DREQ) || (state == S_SREQ);
        mem_addr   = fetch_ptr;
        blk_valid  = (state == S_STREAM);
        blk_addr   = area_addr;
        blk_alg    = cfg_alg;
        blk_first  = first_pend;
        blk_last   = area_end && (sec_ptr == '0);
        dig_done   = (state == S_DONE);
        dig_region = region;
        dig_alg    = cfg_alg;
        busy       = (state != S_IDLE);
    end
endmodule

// File: rtl/rdl_seq_chk.sv
module rdl_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              blk_valid,
    input logic              blk_ready,
    input logic [ADDR_W-1:0] blk_addr,
    input logic [1:0]        blk_alg,
    input logic              blk_last,
    input logic              dig_done,
    input logic [REG_W-1:0]  dig_region,
    input logic              busy
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !blk_valid && !dig_done));

    assert_one_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, blk_valid, dig_done}));

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_last_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready && blk_last) |=> dig_done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dig_done |=> !dig_done);

    assert_hold_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_addr) && $stable(blk_alg)));

    assert_region_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dig_done |-> !$isunknown(dig_region));
endmodule

bind rdl_seq rdl_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .blk_valid (blk_valid),
    .blk_ready (blk_ready),
    .blk_addr  (blk_addr),
    .blk_alg   (blk_alg),
    .blk_last  (blk_last),
    .dig_done  (dig_done),
    .dig_region(dig_region),
    .busy      (busy)
);

// File: tb/rdl_seq_bench.sv
module rdl_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_base = '0;
    logic [2:0]  bw_sel = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        blk_valid;
    logic        blk_ready = 1'b1;
    logic [31:0] blk_addr;
    logic [1:0]  blk_alg;
    logic        blk_first, blk_last, dig_done, busy;
    logic [1:0]  dig_region, dig_alg;

    rdl_seq u_rdl_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base), .bw_sel(bw_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_addr(blk_addr), .blk_alg(blk_alg),
        .blk_first(blk_first), .blk_last(blk_last), .dig_done(dig_done),
        .dig_region(dig_region), .dig_alg(dig_alg), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int dones_seen = 0;
    int last_acc = 0;
    int first_blk_cyc = -1;

    logic [31:0] mem [logic [31:0]];
    logic [43:0] exp_blk [$];   // {addr, alg, first, last, gap}
    logic [3:0]  exp_done [$];  // {region, alg}
    logic [31:0] req_log [$];
    int          req_cyc [$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        mem[a] = d;
    endtask

    task automatic push_area(input logic [31:0] a, input int n, input logic [1:0] alg,
                             input bit first_area, input bit last_area, input int gap);
        for (int k = 0; k < n; k++) begin
            exp_blk.push_back({a + 32'(64*k), alg, first_area && k == 0,
                               last_area && k == n-1, (k == 0) ? 8'd0 : 8'(gap)});
        end
    endtask

    // memory model: one-cycle response latency
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            pend  = 1'b1;
            paddr = mem_addr;
            req_log.push_back(mem_addr);
            req_cyc.push_back(cyc);
        end
    end
    always @(posedge clk) begin
        cyc++;
        #1;
        mem_rvalid = 1'b0;
        if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem.exists(paddr) ? mem[paddr] : 32'd0;
            pend = 1'b0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && blk_valid && blk_ready) begin
            if (first_blk_cyc < 0) first_blk_cyc = cyc;
            if (exp_blk.size() == 0) begin
                chk(0, "R3 unexpected block", {32'd0, blk_addr}, 64'd0);
            end else begin
                logic [43:0] e;
                e = exp_blk.pop_front();
                chk(blk_addr == e[43:12], "R3 block address", blk_addr, e[43:12]);
                chk(blk_alg == e[11:10], "R3/R5 block algorithm", blk_alg, e[11:10]);
                chk({blk_first, blk_last} == e[9:8], "R4 first/last markers",
                    {blk_first, blk_last}, e[9:8]);
                if (e[7:0] != 0)
                    chk(cyc - last_acc == int'(e[7:0]), "R10 block spacing",
                        cyc - last_acc, e[7:0]);
            end
            last_acc = cyc;
        end
        if (rst_n && dig_done) begin
            dones_seen++;
            if (exp_done.size() == 0) begin
                chk(0, "R6 unexpected digest event", {dig_region, dig_alg}, 0);
            end else begin
                logic [3:0] d;
                d = exp_done.pop_front();
                chk({dig_region, dig_alg} == d, "R6/R8/R9 digest region and alg",
                    {dig_region, dig_alg}, d);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        dones_seen = 0;
        first_blk_cyc = -1;
        req_log.delete();
        req_cyc.delete();
    endtask

    task automatic kick(input logic [31:0] base, input logic [2:0] b);
        @(posedge clk); #1;
        list_base = base;
        bw_sel = b;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_dones(input int n);
        int t = 0;
        while (dones_seen < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(dones_seen >= n, "R6 digest event count", dones_seen, n);
    endtask

    task automatic drained(input string tag);
        chk(exp_blk.size() == 0, tag, exp_blk.size(), 0);
        chk(exp_done.size() == 0, tag, exp_done.size(), 0);
    endtask

    initial begin
        // watchdog
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(!busy && !mem_req && !blk_valid && !dig_done, "R1 reset state",
            {busy, mem_req, blk_valid, dig_done}, 0);

        // T2: single region, both end flags set, stalled engine at start
        wr(32'h1000, 32'h7000); wr(32'h1004, 32'h1003);
        wr(32'h1008, 32'd2);    wr(32'h100C, 32'd0);
        push_area(32'h7000, 3, 2'd1, 1, 1, 1);
        exp_done.push_back({2'd0, 2'd1});
        blk_ready = 1'b0;
        kick(32'h1000, 3'd0);
        begin
            int t = 0;
            while (!blk_valid && t < 200) begin @(negedge clk); t++; end
        end
        repeat (3) @(negedge clk);
        chk(blk_valid && blk_addr == 32'h7000, "R11 offer held under stall",
            {blk_valid, blk_addr}, {1'b1, 32'h7000});
        chk(req_log.size() == 4, "R2 descriptor read count", req_log.size(), 4);
        for (int i = 0; i < 4 && i < req_log.size(); i++)
            chk(req_log[i] == 32'h1000 + 32'(4*i), "R2 descriptor word address",
                req_log[i], 32'h1000 + 32'(4*i));
        @(posedge clk); #1 blk_ready = 1'b1;
        wait_dones(1);
        repeat (6) @(negedge clk);
        chk(!busy && req_log.size() == 4, "R7 stop flag wins over wrap, walk idle",
            {busy, 8'(req_log.size())}, {1'b0, 8'd4});
        drained("R3 T2 scoreboard drained");

        // T3: secondary gather list and throttle B=2
        do_reset();
        wr(32'h2000, 32'h8000); wr(32'h2004, 32'h2000);
        wr(32'h2008, 32'd1);    wr(32'h200C, 32'h3000);
        wr(32'h3000, 32'h9000); wr(32'h3004, 32'd0); wr(32'h3008, 32'h3100);
        wr(32'h3100, 32'hA000); wr(32'h3104, 32'd2); wr(32'h3108, 32'd0);
        wr(32'h2010, 32'hB000); wr(32'h2014, 32'h0002);
        wr(32'h2018, 32'd0);    wr(32'h201C, 32'd0);
        push_area(32'h8000, 2, 2'd2, 1, 0, 5);
        push_area(32'h9000, 1, 2'd2, 0, 0, 5);
        push_area(32'hA000, 3, 2'd2, 0, 1, 5);
        exp_done.push_back({2'd0, 2'd2});
        push_area(32'hB000, 1, 2'd0, 1, 1, 5);
        exp_done.push_back({2'd1, 2'd0});
        kick(32'h2000, 3'd2);
        wait_dones(2);
        repeat (6) @(negedge clk);
        chk(!busy, "R7 walk ends after stop region", busy, 0);
        chk(req_log.size() == 14, "R5 secondary descriptor reads", req_log.size(), 14);
        if (req_log.size() > 5)
            chk(req_log[4] == 32'h3000 && req_log[5] == 32'h3004, "R5 secondary pointer followed",
                {req_log[4], req_log[5]}, {32'h3000, 32'h3004});
        drained("R5 T3 scoreboard drained");

        // T4: wrap flag on second region, B=0
        do_reset();
        wr(32'h4000, 32'hC000); wr(32'h4004, 32'h1000);
        wr(32'h4008, 32'd0);    wr(32'h400C, 32'd0);
        wr(32'h4010, 32'hD000); wr(32'h4014, 32'h0001);
        wr(32'h4018, 32'd1);    wr(32'h401C, 32'd0);
        for (int r = 0; r < 2; r++) begin
            push_area(32'hC000, 1, 2'd1, 1, 1, 1);
            exp_done.push_back({2'd0, 2'd1});
            push_area(32'hD000, 2, 2'd0, 1, 1, 1);
            exp_done.push_back({2'd1, 2'd0});
        end
        kick(32'h4000, 3'd0);
        wait_dones(4);
        chk(req_log.size() >= 9 && req_log[8] == 32'h4000, "R8 wrap re-reads list head",
            req_log.size() >= 9 ? req_log[8] : 32'hFFFF_FFFF, 32'h4000);
        drained("R8 T4 scoreboard drained");

        // T5: four flagless regions, index wraps after region 3
        do_reset();
        for (int r = 0; r < 4; r++) begin
            wr(32'h5000 + 32'(16*r), 32'hE000 + 32'(256*r));
            wr(32'h5004 + 32'(16*r), 32'((r % 3) << 12));
            wr(32'h5008 + 32'(16*r), 32'd0);
            wr(32'h500C + 32'(16*r), 32'd0);
        end
        for (int r = 0; r < 5; r++) begin
            push_area(32'hE000 + 32'(256*(r % 4)), 1, 2'((r % 4) % 3), 1, 1, 1);
            exp_done.push_back({2'(r % 4), 2'((r % 4) % 3)});
        end
        kick(32'h5000, 3'd0);
        wait_dones(5);
        chk(req_log.size() >= 17 && req_log[4] == 32'h5010 && req_log[16] == 32'h5000,
            "R9 sequential advance and wrap after region 3",
            req_log.size() >= 17 ? {req_log[4], req_log[16]} : 64'd0, {32'h5010, 32'h5000});
        drained("R9 T5 scoreboard drained");

        do_reset();
        @(negedge clk);
        chk(!busy && !blk_valid, "R1 idle after mid-walk reset", {busy, blk_valid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule